// File: doc/BRIEF.md
# Register-Driven I2C Master Controller

This block lets firmware run an I2C master transfer one step at a time through five byte-wide registers on a simple memory-mapped port. Firmware sets the mode and line enable in a status register, places an address or data byte in a data shift register, and starts, continues or ends a transfer. Each step becomes a byte-level command to a bus engine. The engine does the actual bit timing and returns an acknowledge result and, for reads, a byte.

There is no queue. Progress is paced by an interrupt-pending bit that firmware clears by writing zero to it. It is also paced by the side effects of writing or reading the data register. A data-ready flag records whether firmware has supplied (transmit) or collected (receive) the current byte since the last bus step. A level interrupt output follows the pending bit.

Top module: `i2c_host_ctrl`

## Requirements
- R1: The register offsets are 0x00 control, 0x04 status, 0x08 own address, 0x0C data and 0x10 line control. Any other offset reads 0x00 and ignores writes. After reset the registers read control 0x00, status 0x00, own address 0xFF, data 0xFF and line control 0x00, and the data-ready flag is set.
- R2: Control bit 7 is acknowledge enable, bit 5 is interrupt enable and bit 4 is pending. A control write never sets pending. Writing 0 to pending while it is 1 clears pending and drops the interrupt. If the written interrupt enable is 0, that write also clears busy.
- R3: Pending and the interrupt output are raised by a completed bus step only while interrupt enable is 1.
- R4: When a control write clears pending and busy stays 1, the block acts on the data-ready flag. If the flag is set, it issues a send (mode 3) or a receive (mode 2). If the flag is clear, it raises pending and the interrupt again and issues no command.
- R5: In the status register, bits 7:6 are the mode (2 is master receive, 3 is master transmit), bit 5 is busy, bit 4 is output enable and bit 0 is the not-acknowledged flag. A status write keeps busy and takes the other bits from the written value. If the written output enable is 0, the write clears busy, sets data-ready and drops the interrupt.
- R6: A status write with bits 7 and 5 set and output enable 1 clears bit 0, sets busy and issues a start carrying the data byte (address in bits 7:1, direction in bit 0). If the engine reports a not-acknowledged address while acknowledge enable is 1, bit 0 is set and no receive follows. Otherwise, in mode 2, one receive is issued at once. The interrupt is raised when the last step completes.
- R7: A status write with bit 7 set, bit 5 clear and output enable 1 issues a stop and sets data-ready. It clears busy only if pending is 0.
- R8: The own-address register accepts writes only while output enable is 0. The data register accepts writes only while output enable is 1.
- R9: A data write sets data-ready. In mode 3 with busy 1 and pending 0, it also issues a send of the new byte.
- R10: A data read returns the stored byte and sets data-ready. In mode 2 with busy 1 and pending 0, it also issues a receive.
- R11: Issuing a send or receive clears bit 0 and data-ready. When the step completes not-acknowledged with acknowledge enable 1, bit 0 is set and the data register is left unchanged. In every other receive case, the returned byte is stored.
- R12: Each command to the engine is a one-cycle pulse carrying an opcode (0 start, 1 send, 2 receive, 3 stop) and a byte. Only one command is outstanding at a time. The effects that depend on a result are applied in the cycle in which the engine's done pulse is registered.
- R13: The line-control register is plain read/write storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| irq | output | 1 | Level interrupt |
| eng_cmd_valid | output | 1 | One-cycle command pulse to the bus engine |
| eng_cmd_op | output | 2 | Command opcode |
| eng_cmd_byte | output | 8 | Address or data byte for start and send |
| eng_done | input | 1 | Engine completion pulse |
| eng_nack | input | 1 | Completion was not acknowledged |
| eng_rx_byte | input | 8 | Byte returned by a receive |

## Verification
A register access takes effect at the clock edge that samples it. A command pulse is visible in the cycle after that edge. Results from the engine, including interrupt and status changes, appear in the cycle after the engine's done pulse is registered. The bench drives accesses and engine replies on falling edges and reads register values before the access edge. After a command, it waits for the interrupt, or for a fixed idle window longer than the engine's reply latency, before sampling status, data or the command log. Checks that no command was issued compare the command count across that same idle window.

// File: rtl/i2c_host_pkg.sv
// Package: shared constants and types for the I2C master controller.
// Assumes byte-wide registers on a 5-bit byte-offset map.
package i2c_host_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int REG_CNT  = 5;

    // register slots, in decode order
    localparam int SLOT_CON = 0;
    localparam int SLOT_STA = 1;
    localparam int SLOT_OWN = 2;
    localparam int SLOT_DAT = 3;
    localparam int SLOT_LC  = 4;

    localparam logic [ADDR_W-1:0] SLOT_OFS [REG_CNT] =
        '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10};

    // control bits
    localparam int CB_ACK  = 7;
    localparam int CB_IE   = 5;
    localparam int CB_PEND = 4;

    // status bits
    localparam int SB_MODE_HI = 7;
    localparam int SB_MODE_LO = 6;
    localparam int SB_BUSY    = 5;
    localparam int SB_OE      = 4;
    localparam int SB_NACK    = 0;

    localparam logic [1:0] MODE_MRX = 2'd2;
    localparam logic [1:0] MODE_MTX = 2'd3;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_e;

endpackage

// File: rtl/i2c_host_dec.sv
// Module: register address decoder.
// Produces one hit line per register slot; no hit for unmapped offsets.
module i2c_host_dec
    import i2c_host_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic [REG_CNT-1:0] hit
);

    // one comparator per slot
    for (genvar i = 0; i < REG_CNT; i++) begin : g_slot
        assign hit[i] = (addr == SLOT_OFS[i]);
    end

endmodule

// File: rtl/i2c_host_cmd_track.sv
// Module: outstanding-command tracker.
// Remembers the opcode of the command in flight and routes the engine's
// done pulse to a per-kind completion strobe. Assumes one command at a time.
module i2c_host_cmd_track
    import i2c_host_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  eng_op_e cmd_op,
    input  logic    eng_done,
    output logic    done_start,
    output logic    done_send,
    output logic    done_recv,
    output logic    waiting
);

    eng_op_e op_q;

    // track the command in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting <= 1'b0;
            op_q    <= OP_STOP;
        end else if (cmd_valid) begin
            waiting <= 1'b1;
            op_q    <= cmd_op;
        end else if (eng_done) begin
            waiting <= 1'b0;
        end
    end

    assign done_start = eng_done && waiting && (op_q == OP_START);
    assign done_send  = eng_done && waiting && (op_q == OP_SEND);
    assign done_recv  = eng_done && waiting && (op_q == OP_RECV);

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !waiting); // R12

endmodule

// File: rtl/i2c_host_ctrl.sv
// Module: register-programmed I2C master controller (top).
// Holds the five registers, applies access side effects and engine results,
// and issues byte-level commands. Assumes register accesses and engine done
// pulses do not coincide with each other in a way firmware would not produce.
module i2c_host_ctrl
    import i2c_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_cmd_op,
    output logic [DATA_W-1:0] eng_cmd_byte,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [DATA_W-1:0] eng_rx_byte
);

    localparam logic [DATA_W-1:0] RST_ONES = {DATA_W{1'b1}};

    logic [REG_CNT-1:0] hit;
    logic [DATA_W-1:0]  con_q, sta_q, own_q, dat_q, lc_q;
    logic [DATA_W-1:0]  con_n, sta_n, own_n, dat_n, lc_n;
    logic               rdy_q, rdy_n, irq_q, irq_n;
    logic               issue;
    eng_op_e            issue_op, op_q;
    logic [DATA_W-1:0]  byte_q;
    logic               valid_q;
    logic               done_start, done_send, done_recv, waiting;
    logic               wr, rd;
    logic [1:0]         mode_n;

    i2c_host_dec u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    i2c_host_cmd_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (valid_q),
        .cmd_op     (op_q),
        .eng_done   (eng_done),
        .done_start (done_start),
        .done_send  (done_send),
        .done_recv  (done_recv),
        .waiting    (waiting)
    );

    assign wr = bus_sel && bus_we;
    assign rd = bus_sel && !bus_we;

    // next-state: engine results first, then the register access
    always_comb begin
        con_n    = con_q;
        sta_n    = sta_q;
        own_n    = own_q;
        dat_n    = dat_q;
        lc_n     = lc_q;
        rdy_n    = rdy_q;
        irq_n    = irq_q;
        issue    = 1'b0;
        issue_op = OP_STOP;

        if (done_start) begin
            if (eng_nack && con_q[CB_ACK]) begin
                sta_n[SB_NACK] = 1'b1;
                if (con_q[CB_IE]) begin con_n[CB_PEND] = 1'b1; irq_n = 1'b1; end
            end else if (sta_q[SB_MODE_HI:SB_MODE_LO] == MODE_MRX) begin
                sta_n[SB_NACK] = 1'b0;
                rdy_n    = 1'b0;
                issue    = 1'b1;
                issue_op = OP_RECV;
            end else if (con_q[CB_IE]) begin
                con_n[CB_PEND] = 1'b1;
                irq_n = 1'b1;
            end
        end
        if (done_send || done_recv) begin
            if (eng_nack && con_q[CB_ACK]) sta_n[SB_NACK] = 1'b1;
            else if (done_recv)            dat_n = eng_rx_byte;
            if (con_q[CB_IE]) begin con_n[CB_PEND] = 1'b1; irq_n = 1'b1; end
        end

        if (wr && hit[SLOT_CON]) begin
            con_n = {bus_wdata[7:5], con_n[CB_PEND], bus_wdata[3:0]};
            if (con_n[CB_PEND] && !bus_wdata[CB_PEND]) begin
                con_n[CB_PEND] = 1'b0;
                irq_n = 1'b0;
                if (!con_n[CB_IE]) sta_n[SB_BUSY] = 1'b0;
                if (sta_n[SB_BUSY]) begin
                    if (rdy_n) begin
                        if (sta_n[SB_MODE_HI:SB_MODE_LO] == MODE_MTX) begin
                            sta_n[SB_NACK] = 1'b0; rdy_n = 1'b0;
                            issue = 1'b1; issue_op = OP_SEND;
                        end else if (sta_n[SB_MODE_HI:SB_MODE_LO] == MODE_MRX) begin
                            sta_n[SB_NACK] = 1'b0; rdy_n = 1'b0;
                            issue = 1'b1; issue_op = OP_RECV;
                        end
                    end else begin
                        con_n[CB_PEND] = 1'b1;
                        irq_n = 1'b1;
                    end
                end
            end
        end

        if (wr && hit[SLOT_STA]) begin
            sta_n = {bus_wdata[7:6], sta_n[SB_BUSY], bus_wdata[4:0]};
            if (!bus_wdata[SB_OE]) begin
                sta_n[SB_BUSY] = 1'b0;
                rdy_n = 1'b1;
                irq_n = 1'b0;
            end else if (bus_wdata[SB_MODE_HI]) begin
                if (bus_wdata[SB_BUSY]) begin
                    sta_n[SB_NACK] = 1'b0;
                    sta_n[SB_BUSY] = 1'b1;
                    rdy_n    = 1'b0;
                    issue    = 1'b1;
                    issue_op = OP_START;
                end else begin
                    issue    = 1'b1;
                    issue_op = OP_STOP;
                    rdy_n    = 1'b1;
                    if (!con_n[CB_PEND]) sta_n[SB_BUSY] = 1'b0;
                end
            end
        end

        if (wr && hit[SLOT_OWN] && !sta_q[SB_OE]) own_n = bus_wdata;
        if (wr && hit[SLOT_LC])                   lc_n  = bus_wdata;

        mode_n = sta_n[SB_MODE_HI:SB_MODE_LO];
        if (wr && hit[SLOT_DAT] && sta_q[SB_OE]) begin
            dat_n = bus_wdata;
            rdy_n = 1'b1;
            if (mode_n == MODE_MTX && sta_n[SB_BUSY] && !con_n[CB_PEND]) begin
                sta_n[SB_NACK] = 1'b0; rdy_n = 1'b0;
                issue = 1'b1; issue_op = OP_SEND;
            end
        end
        if (rd && hit[SLOT_DAT]) begin
            rdy_n = 1'b1;
            if (mode_n == MODE_MRX && sta_n[SB_BUSY] && !con_n[CB_PEND]) begin
                sta_n[SB_NACK] = 1'b0; rdy_n = 1'b0;
                issue = 1'b1; issue_op = OP_RECV;
            end
        end
    end

    // register update and command pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            con_q   <= '0;
            sta_q   <= '0;
            own_q   <= RST_ONES;
            dat_q   <= RST_ONES;
            lc_q    <= '0;
            rdy_q   <= 1'b1;
            irq_q   <= 1'b0;
            valid_q <= 1'b0;
            op_q    <= OP_STOP;
            byte_q  <= '0;
        end else begin
            con_q   <= con_n;
            sta_q   <= sta_n;
            own_q   <= own_n;
            dat_q   <= dat_n;
            lc_q    <= lc_n;
            rdy_q   <= rdy_n;
            irq_q   <= irq_n;
            valid_q <= issue;
            if (issue) begin
                op_q   <= issue_op;
                byte_q <= dat_n;
            end
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (hit[SLOT_CON]) bus_rdata = con_q;
        if (hit[SLOT_STA]) bus_rdata = sta_q;
        if (hit[SLOT_OWN]) bus_rdata = own_q;
        if (hit[SLOT_DAT]) bus_rdata = dat_q;
        if (hit[SLOT_LC])  bus_rdata = lc_q;
    end

    assign irq           = irq_q;
    assign eng_cmd_valid = valid_q;
    assign eng_cmd_op    = op_q;
    assign eng_cmd_byte  = byte_q;

    AST_PEND_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(con_q[CB_PEND]) |-> con_q[CB_IE]); // R3

    AST_CON_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit[SLOT_CON] && !con_q[CB_PEND] && !eng_done) |=> !con_q[CB_PEND]); // R2

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit[SLOT_STA] && !bus_wdata[SB_OE]) |=> (!sta_q[SB_BUSY] && !irq)); // R5

    AST_OWN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit[SLOT_OWN] && sta_q[SB_OE]) |=> $stable(own_q)); // R8

endmodule

// File: tb/i2c_host_ctrl_test.sv
module i2c_host_ctrl_test;
    import i2c_host_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       eng_cmd_valid;
    logic [1:0] eng_cmd_op;
    logic [7:0] eng_cmd_byte;
    logic       eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0] eng_rx_byte = '0;

    int checks = 0, errors = 0;
    int cmd_cnt = 0, cnt = 0;
    logic [1:0] last_op = '0;
    logic [7:0] last_byte = '0;
    logic       cfg_addr_nack = 1'b0, cfg_data_nack = 1'b0;
    logic [7:0] cfg_rx = '0;
    logic       finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    i2c_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .eng_cmd_valid(eng_cmd_valid), .eng_cmd_op(eng_cmd_op),
        .eng_cmd_byte(eng_cmd_byte), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_rx_byte(eng_rx_byte)
    );

    // byte-level engine model: done three falling edges after a command
    always @(negedge clk) begin
        eng_done <= 1'b0;
        if (eng_cmd_valid) begin
            cnt       <= 3;
            last_op   <= eng_cmd_op;
            last_byte <= eng_cmd_byte;
            cmd_cnt   <= cmd_cnt + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                eng_done    <= 1'b1;
                eng_nack    <= (last_op == 2'd0) ? cfg_addr_nack : cfg_data_nack;
                eng_rx_byte <= cfg_rx;
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input string req);
        for (int i = 0; i < 40 && !irq; i++) @(negedge clk);
        chk(req, {7'd0, irq}, 8'd1);
    endtask

    // {write, offset, data, expected read}
    typedef struct packed { logic w; logic [4:0] a; logic [7:0] d; logic [7:0] e; } vec_t;
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'h00, 8'h00, 8'h00},   // R1 reset control
        '{1'b0, 5'h04, 8'h00, 8'h00},   // R1 reset status
        '{1'b0, 5'h08, 8'h00, 8'hFF},   // R1 reset own address
        '{1'b0, 5'h0C, 8'h00, 8'hFF},   // R1 reset data
        '{1'b0, 5'h10, 8'h00, 8'h00},   // R1 reset line control
        '{1'b1, 5'h10, 8'h5A, 8'h5A},   // R13 storage
        '{1'b1, 5'h14, 8'h77, 8'h00},   // R1 unmapped
        '{1'b0, 5'h10, 8'h00, 8'h5A},   // R1 unmapped write ignored
        '{1'b1, 5'h08, 8'h3C, 8'h3C},   // R8 own writable with output off
        '{1'b1, 5'h0C, 8'h12, 8'hFF},   // R8 data locked with output off
        '{1'b1, 5'h00, 8'h10, 8'h00},   // R2 pending not settable
        '{1'b1, 5'h00, 8'hA0, 8'hA0},   // R2 control bits
        '{1'b1, 5'h04, 8'hC0, 8'hC0},   // R5 status takes written bits
        '{1'b1, 5'h04, 8'h00, 8'h00}    // R5 output off
    };

    initial begin
        logic [7:0] v;
        int c0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 irq reset", {7'd0, irq}, 8'd0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].w) wr(VEC[i].a, VEC[i].d);
            rd_chk($sformatf("R1/R2/R5/R8/R13 vector %0d", i), VEC[i].a, VEC[i].e);
        end

        // transmit path
        wr(5'h04, 8'hD0); idle(8);                       // R7 stop, mode 3
        chk("R7 stop opcode", {6'd0, last_op}, 8'd3);
        wr(5'h08, 8'h99);
        rd_chk("R8 own locked with output on", 5'h08, 8'h3C);
        wr(5'h0C, 8'hA4);
        wr(5'h04, 8'hF0);
        wait_irq("R6 start interrupt");
        chk("R12 start opcode", {6'd0, last_op}, 8'd0);
        chk("R6 start byte", last_byte, 8'hA4);
        rd_chk("R6 status after start", 5'h04, 8'hF0);
        rd_chk("R3 pending set", 5'h00, 8'hB0);
        c0 = cmd_cnt;
        wr(5'h0C, 8'h3C); idle(8);
        chk("R9 no send while pending", cmd_cnt[7:0], c0[7:0]);
        wr(5'h00, 8'hA0);
        idle(1);
        chk("R2 clear lowers irq", {7'd0, irq}, 8'd0);
        wait_irq("R4 send done interrupt");
        chk("R4 send opcode", {6'd0, last_op}, 8'd1);
        chk("R9 send byte", last_byte, 8'h3C);
        c0 = cmd_cnt;
        wr(5'h00, 8'hA0); idle(6);
        chk("R4 not ready reraise", {7'd0, irq}, 8'd1);
        chk("R4 no command when not ready", cmd_cnt[7:0], c0[7:0]);
        wr(5'h0C, 8'h77);
        cfg_data_nack = 1'b1;
        wr(5'h00, 8'hA0);
        idle(2); wait_irq("R11 send nack interrupt");
        rd_chk("R11 nack flag", 5'h04, 8'hF1);
        cfg_data_nack = 1'b0;
        wr(5'h04, 8'hD0); idle(8);
        rd_chk("R7 busy kept while pending", 5'h04, 8'hF0);
        wr(5'h00, 8'h80);
        rd_chk("R2 ie off clears busy", 5'h04, 8'hD0);
        chk("R2 irq low", {7'd0, irq}, 8'd0);

        // receive path, chained receive after address
        wr(5'h00, 8'hA0);
        wr(5'h04, 8'h90); idle(8);
        wr(5'h0C, 8'hA5);
        cfg_rx = 8'h6B;
        wr(5'h04, 8'hB0);
        idle(6); wait_irq("R6 chained receive interrupt");
        chk("R6 chained receive opcode", {6'd0, last_op}, 8'd2);
        rd_chk("R6 status rx", 5'h04, 8'hB0);
        rd_chk("R11 received byte", 5'h0C, 8'h6B);
        cfg_rx = 8'h11; cfg_data_nack = 1'b1;
        wr(5'h00, 8'hA0);
        idle(2); wait_irq("R4 receive interrupt");
        rd_chk("R11 nack status", 5'h04, 8'hB1);
        rd_chk("R11 data unchanged on nack", 5'h0C, 8'h6B);
        cfg_rx = 8'h22;
        wr(5'h00, 8'h20);
        idle(2); wait_irq("R11 receive without ack enable");
        rd_chk("R11 nack ignored w/o ack enable", 5'h04, 8'hB0);
        rd_chk("R11 byte stored", 5'h0C, 8'h22);
        cfg_data_nack = 1'b0;
        wr(5'h04, 8'h00);
        chk("R5 output off lowers irq", {7'd0, irq}, 8'd0);
        rd_chk("R5 status cleared", 5'h04, 8'h00);
        rd_chk("R5 pending kept", 5'h00, 8'h30);
        wr(5'h00, 8'h80);

        // receive with interrupts off: read triggers next receive
        wr(5'h04, 8'h90); idle(8);
        wr(5'h0C, 8'hA5);
        cfg_rx = 8'h44;
        wr(5'h04, 8'hB0); idle(14);
        chk("R3 no irq with ie off", {7'd0, irq}, 8'd0);
        c0 = cmd_cnt;
        cfg_rx = 8'h55;
        rd_chk("R10 read returns byte", 5'h0C, 8'h44);
        idle(8);
        chk("R10 read issued receive", cmd_cnt[7:0], c0[7:0] + 8'd1);
        rd_chk("R10 next byte", 5'h0C, 8'h55);
        idle(8);
        rd_chk("R3 pending never set", 5'h00, 8'h80);

        // address not acknowledged in receive mode
        wr(5'h00, 8'hA0);
        wr(5'h04, 8'h00);
        wr(5'h04, 8'h90); idle(8);
        wr(5'h0C, 8'hA5);
        cfg_addr_nack = 1'b1;
        c0 = cmd_cnt;
        wr(5'h04, 8'hB0);
        idle(2); wait_irq("R6 address nack interrupt");
        idle(8);
        chk("R6 no receive after nack", cmd_cnt[7:0], c0[7:0] + 8'd1);
        rd_chk("R6 nack status", 5'h04, 8'hB1);
        rd_chk("R6 pending", 5'h00, 8'hB0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule